// File: doc/BRIEF.md
# Clock and Reset Control Register Bank

This block is a bank of 32-bit control words for clocks and resets, reached through a plain word bus inside a 4 KiB address window. The word index is the byte address shifted right by two. The two low address bits are ignored. Each word is loaded with a fixed power-on value when `rst_n` is low. After that, software reads and writes the words one at a time.

Most words are ordinary storage. A few follow their own rules:
- The four PLL words keep a lock indicator and a sticky loss-of-lock flag.
- The software-reset word always reads back as zero.
- The seconds and tick words show the values of an external counter block and discard writes.

Three watchdog event inputs pass through a gate. Each event is gated by bit 0 of its own watchdog control word. A rising edge on an enabled input produces a one-cycle pulse on the CPU core reset output.

The pulse comes from a two-state machine. In `WD_IDLE` the output is low. A gated rising edge seen in any state takes the transition *fire* into `WD_PULSE`. In `WD_PULSE` the output is high. With no gated edge, the transition *expire* returns the machine to `WD_IDLE`. A gated edge while in `WD_PULSE` takes the transition *refire*, which keeps the machine in `WD_PULSE`.

Top module: `clk_ctrl_regs`

## Requirements
- R1: After reset, the words read back with the following values:
  - 0x00, 0x28 and 0x30: 0xFFFFFFFF.
  - 0x38, 0x3C and 0x40 (the watchdog control words): 0xFFFFFFFF.
  - 0x04: 0x004AAAAA.
  - 0x08: 0x5413F855.
  - 0x2C: 0xAA4F8F9F.
  - 0x20: 0x00001000.
  - 0x24: 0x80000000.
  - 0x34: 0x03000000.
  - 0x44: 0x00000003.
  - 0x5C: 0x04000003.
  - 0x64: 0x000000C8.
  - PLL words: 0x0C is 0x80222101, 0x10 is 0x80202101, 0x54 is 0x80C02105 and 0x60 is 0x81228606.
  - Every other word inside the window reads 0.
  - `cpu_rst_o` is low.
- R2: A write to an ordinary word stores `wdata` whole. The `rdata` output carries the addressed word in the cycle after `rd_en`, and keeps that value until the next `rd_en`.
- R3: An address at or above 0x70 reads as 0. Writes to such an address change nothing.
- R4: A write to a PLL word (0x0C, 0x10, 0x54 or 0x60) with bit 12 set stores `wdata` with bit 31 cleared and bit 30 set.
- R5: A write to a PLL word with bit 12 clear stores `wdata` with bit 31 set. Bit 30 is cleared if `wdata[30]` is 1, and keeps its old value if `wdata[30]` is 0.
- R6: The software-reset word at 0x14 always reads 0, whatever was written to it.
- R7: Reads of 0x68 return `sec_count_i`, and reads of 0x6C return `tick_count_i`. Writes to these two addresses have no effect.
- R8: A rising edge on `wdog_evt_i[n]` while bit 0 of the watchdog control word for input n is 1 raises `cpu_rst_o` for exactly the next cycle. The control word for input n is at 0x38 + 4n.
- R9: A rising edge on `wdog_evt_i[n]` while that bit 0 is 0 leaves `cpu_rst_o` low.
- R10: When a write to a watchdog control word falls in the same cycle as that input's rising edge, the gate uses the value held before the write.
- R11: A read and a write to the same word in the same cycle return the old value. The new value is visible from the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| addr | input | 12 | Byte address inside the window |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| sec_count_i | input | 32 | Seconds value from the counter block |
| tick_count_i | input | 32 | Tick value from the counter block |
| wdog_evt_i | input | 3 | Watchdog reset events |
| cpu_rst_o | output | 1 | One-cycle CPU core reset pulse |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a bus write to a watchdog control word and a rising edge on the matching watchdog input. The bench raises the event on the same clock edge at which the write commits. It then judges the outcome by whether `cpu_rst_o` pulses. The pulse must follow the old gate bit, in both directions: a gate being cleared and a gate being set.

The second pair is a read and a write to the same word in one cycle. The returned value must be the old contents, and a following read must show the new ones.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_REGS  = 28;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int NUM_WDOG  = 3;

    localparam int IX_SWRESET = 5;
    localparam int IX_WDCTL0  = 14;
    localparam int IX_SEC     = 26;
    localparam int IX_TICK    = 27;

    localparam int LOCK_BIT  = 31;
    localparam int LOSS_BIT  = 30;
    localparam int PDOWN_BIT = 12;

    typedef enum logic [1:0] {
        SLOT_PLAIN,
        SLOT_PLL,
        SLOT_WONLY,
        SLOT_COUNTER
    } slot_kind_e;

    typedef enum logic {
        WD_IDLE,
        WD_PULSE
    } wd_state_e;

    function automatic slot_kind_e slot_kind(input int idx);
        case (idx)
            3, 4, 21, 24:   return SLOT_PLL;
            IX_SWRESET:     return SLOT_WONLY;
            IX_SEC, IX_TICK: return SLOT_COUNTER;
            default:        return SLOT_PLAIN;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_reset(input int idx);
        case (idx)
            0, 10, 12, 14, 15, 16: return 32'hFFFF_FFFF;
            1:  return 32'h004A_AAAA;
            2:  return 32'h5413_F855;
            3:  return 32'h8022_2101;
            4:  return 32'h8020_2101;
            8:  return 32'h0000_1000;
            9:  return 32'h8000_0000;
            11: return 32'hAA4F_8F9F;
            13: return 32'h0300_0000;
            17: return 32'h0000_0003;
            21: return 32'h80C0_2105;
            23: return 32'h0400_0003;
            24: return 32'h8122_8606;
            25: return 32'h0000_00C8;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cc_pll_slot.sv
module cc_pll_slot
    import cc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = wdata;
        if (wdata[PDOWN_BIT]) begin
            nxt[LOCK_BIT] = 1'b0;
            nxt[LOSS_BIT] = 1'b1;
        end else begin
            nxt[LOCK_BIT] = 1'b1;
            nxt[LOSS_BIT] = wdata[LOSS_BIT] ? 1'b0 : q[LOSS_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (wr_hit)
            q <= nxt;
    end

    a_r4_pdown_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata[PDOWN_BIT]) |=> (!q[LOCK_BIT] && q[LOSS_BIT]));

    a_r5_normal_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wdata[PDOWN_BIT]) |=> q[LOCK_BIT]);

    a_r5_zero_keeps_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wdata[PDOWN_BIT] && !wdata[LOSS_BIT]) |=> $stable(q[LOSS_BIT]));

endmodule

// File: rtl/cc_reg_bank.sv
module cc_reg_bank
    import cc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_go,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  words
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam slot_kind_e        KIND = slot_kind(i);
        localparam logic [DATA_W-1:0] RV   = slot_reset(i);

        logic hit;
        assign hit = wr_go && (wr_idx == IDX_W'(i));

        if (KIND == SLOT_PLL) begin : g_pll
            cc_pll_slot #(.RESET_VAL(RV)) u_pll (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (hit),
                .wdata  (wdata),
                .q      (words[i])
            );
        end else if (KIND == SLOT_PLAIN) begin : g_plain
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= RV;
                else if (hit)
                    q <= wdata;
            end
            assign words[i] = q;
        end else begin : g_empty
            logic unused_hit;
            assign unused_hit = hit;
            assign words[i]   = '0;
        end
    end

endmodule

// File: rtl/cc_wdog_gate.sv
module cc_wdog_gate
    import cc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WDOG-1:0] evt,
    input  logic [NUM_WDOG-1:0] gate,
    output logic                cpu_rst
);

    logic [NUM_WDOG-1:0] evt_q;
    logic [NUM_WDOG-1:0] rise;
    logic                fire;
    wd_state_e           state_q, state_d;

    assign rise = evt & ~evt_q;
    assign fire = |(rise & gate);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  state_d = fire ? WD_PULSE : WD_IDLE;   // fire
            WD_PULSE: state_d = fire ? WD_PULSE : WD_IDLE;   // refire / expire
            default:  state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            evt_q   <= evt;
        end
    end

    always_comb begin
        cpu_rst = (state_q == WD_PULSE);
    end

    a_r8_gated_rise_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & gate)) |=> cpu_rst);

    a_r9_blocked_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(rise & gate)) |=> !cpu_rst);

endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
    import cc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rdata,
    input  logic [DATA_W-1:0]   sec_count_i,
    input  logic [DATA_W-1:0]   tick_count_i,
    input  logic [NUM_WDOG-1:0] wdog_evt_i,
    output logic                cpu_rst_o
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]                widx;
    logic [IDX_W-1:0]                 sidx;
    logic                             in_range;
    logic                             unused_lsb;
    logic [NUM_REGS-1:0][DATA_W-1:0]  words;
    logic [NUM_WDOG-1:0]              gate;
    logic [DATA_W-1:0]                rd_word;
    logic [DATA_W-1:0]                rdata_q;

    assign widx       = addr[ADDR_W-1:2];
    assign sidx       = widx[IDX_W-1:0];
    assign in_range   = widx < WIDX_W'(NUM_REGS);
    assign unused_lsb = ^addr[1:0];

    cc_reg_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_en && in_range),
        .wr_idx (sidx),
        .wdata  (wdata),
        .words  (words)
    );

    for (genvar n = 0; n < NUM_WDOG; n++) begin : g_gate
        assign gate[n] = words[IX_WDCTL0 + n][0];
    end

    cc_wdog_gate u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (wdog_evt_i),
        .gate    (gate),
        .cpu_rst (cpu_rst_o)
    );

    always_comb begin
        if (!in_range)
            rd_word = '0;
        else if (sidx == IDX_W'(IX_SEC))
            rd_word = sec_count_i;
        else if (sidx == IDX_W'(IX_TICK))
            rd_word = tick_count_i;
        else
            rd_word = words[sidx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_word;
    end

    assign rdata = rdata_q;

    a_r2_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    a_r3_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_range) |=> (rdata == '0));

    a_r6_swreset_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_range && sidx == IDX_W'(IX_SWRESET)) |=> (rdata == '0));

    a_r7_sec_from_counter: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_range && sidx == IDX_W'(IX_SEC)) |=> (rdata == $past(sec_count_i)));

endmodule

// File: tb/test_clk_ctrl_regs.sv
module test_clk_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [31:0] sec_count_i = '0;
    logic [31:0] tick_count_i = '0;
    logic [2:0]  wdog_evt_i = '0;
    logic        cpu_rst_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    clk_ctrl_regs i_clk_ctrl_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wdata        (wdata),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .rdata        (rdata),
        .sec_count_i  (sec_count_i),
        .tick_count_i (tick_count_i),
        .wdog_evt_i   (wdog_evt_i),
        .cpu_rst_o    (cpu_rst_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic expect_word(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset;
        check("R1 rdata after reset", rdata, 32'h0);
        check("R1 cpu_rst after reset", {31'h0, cpu_rst_o}, 32'h0);
        expect_word("R1 0x00", 12'h000, 32'hFFFF_FFFF);
        expect_word("R1 0x04", 12'h004, 32'h004A_AAAA);
        expect_word("R1 0x08", 12'h008, 32'h5413_F855);
        expect_word("R1 0x0C", 12'h00C, 32'h8022_2101);
        expect_word("R1 0x10", 12'h010, 32'h8020_2101);
        expect_word("R1 0x20", 12'h020, 32'h0000_1000);
        expect_word("R1 0x24", 12'h024, 32'h8000_0000);
        expect_word("R1 0x2C", 12'h02C, 32'hAA4F_8F9F);
        expect_word("R1 0x34", 12'h034, 32'h0300_0000);
        expect_word("R1 0x3C", 12'h03C, 32'hFFFF_FFFF);
        expect_word("R1 0x44", 12'h044, 32'h0000_0003);
        expect_word("R1 0x48", 12'h048, 32'h0000_0000);
        expect_word("R1 0x54", 12'h054, 32'h80C0_2105);
        expect_word("R1 0x5C", 12'h05C, 32'h0400_0003);
        expect_word("R1 0x60", 12'h060, 32'h8122_8606);
        expect_word("R1 0x64", 12'h064, 32'h0000_00C8);
    endtask

    task automatic t_plain;
        bus_write(12'h028, 32'hA5A5_5A5A);
        expect_word("R2 write/read 0x28", 12'h028, 32'hA5A5_5A5A);
        bus_write(12'h058, 32'h1234_5678);
        expect_word("R2 write/read 0x58", 12'h058, 32'h1234_5678);
        repeat (3) @(negedge clk);
        check("R2 rdata held", rdata, 32'h1234_5678);
    endtask

    task automatic t_range;
        bus_write(12'h070, 32'hDEAD_BEEF);
        expect_word("R3 0x70 reads zero", 12'h070, 32'h0);
        bus_write(12'hFFC, 32'hCAFE_F00D);
        expect_word("R3 0xFFC reads zero", 12'hFFC, 32'h0);
        expect_word("R3 0x00 untouched", 12'h000, 32'hFFFF_FFFF);
    endtask

    task automatic t_pll;
        bus_write(12'h00C, 32'h0000_1000);
        expect_word("R4 power-down", 12'h00C, 32'h4000_1000);
        bus_write(12'h00C, 32'h0000_0000);
        expect_word("R5 zero keeps loss", 12'h00C, 32'hC000_0000);
        bus_write(12'h00C, 32'h4000_0000);
        expect_word("R5 one clears loss", 12'h00C, 32'h8000_0000);
        bus_write(12'h00C, 32'h0000_0000);
        expect_word("R5 stays clear", 12'h00C, 32'h8000_0000);
        bus_write(12'h060, 32'hC000_1234);
        expect_word("R4 power-down 0x60", 12'h060, 32'h4000_1234);
    endtask

    task automatic t_wonly;
        bus_write(12'h014, 32'hFFFF_FFFF);
        expect_word("R6 sw reset reads zero", 12'h014, 32'h0);
    endtask

    task automatic t_counter;
        sec_count_i = 32'h0000_0011; tick_count_i = 32'h0000_0320;
        expect_word("R7 seconds", 12'h068, 32'h0000_0011);
        bus_write(12'h06C, 32'hFFFF_FFFF);
        expect_word("R7 tick after write", 12'h06C, 32'h0000_0320);
        tick_count_i = 32'h0017_D780;
        expect_word("R7 tick follows", 12'h06C, 32'h0017_D780);
    endtask

    task automatic t_wdog;
        @(negedge clk); wdog_evt_i[0] = 1'b1;
        @(negedge clk); check("R8 pulse high", {31'h0, cpu_rst_o}, 32'h1);
        @(negedge clk); check("R8 pulse one cycle", {31'h0, cpu_rst_o}, 32'h0);
        wdog_evt_i[0] = 1'b0;
        bus_write(12'h03C, 32'hFFFF_FFFE);
        @(negedge clk); wdog_evt_i[1] = 1'b1;
        @(negedge clk); check("R9 blocked", {31'h0, cpu_rst_o}, 32'h0);
        @(negedge clk); check("R9 blocked later", {31'h0, cpu_rst_o}, 32'h0);
        wdog_evt_i[1] = 1'b0;
    endtask

    task automatic t_race;
        @(negedge clk);
        addr = 12'h040; wdata = 32'h0; wr_en = 1'b1; wdog_evt_i[2] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 old gate set", {31'h0, cpu_rst_o}, 32'h1);
        wdog_evt_i[2] = 1'b0;
        @(negedge clk); wdog_evt_i[2] = 1'b1;
        @(negedge clk); check("R10 new gate clear", {31'h0, cpu_rst_o}, 32'h0);
        wdog_evt_i[2] = 1'b0;
        @(negedge clk);
        addr = 12'h040; wdata = 32'h1; wr_en = 1'b1; wdog_evt_i[2] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 old gate clear", {31'h0, cpu_rst_o}, 32'h0);
        wdog_evt_i[2] = 1'b0;
    endtask

    task automatic t_rw_same;
        bus_write(12'h030, 32'h0000_0001);
        @(negedge clk);
        addr = 12'h030; wdata = 32'h0000_0002; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11 old value", rdata, 32'h0000_0001);
        expect_word("R11 new value", 12'h030, 32'h0000_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_range();
        t_pll();
        t_wonly();
        t_counter();
        t_wdog();
        t_race();
        t_rw_same();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL all watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule